// File: doc/BRIEF.md
# Synthesizer Configuration Register Bank

This block holds the control settings of a serially configured frequency synthesizer. A serial front end, which sits outside this block, presents one transaction at a time. Each transaction carries a 5-bit address, a 24-bit data word and a write or read strobe. The bank stores a control register and a reference-divider register. It also derives the power enables for six synthesizer sub-blocks.

Reads are indirect. A write to address 0 stores no data. It loads a read pointer and a soft-reset request. A later read strobe captures the register that the pointer selects into the read-data output. A pointer of 0 selects a fixed 24-bit identifier.

The control register chooses where chip enable comes from: an external pin, or a software bit. Each sub-block also has its own keep-on bit, which holds that block powered whatever the chip-enable state.

Top module: `synth_cfg_bank`

## Requirements
- R1: After reset, `rdata` is 0, the read pointer is 0, the soft-reset state is clear, the control register is 0x003 and the divider register is 1.
- R2: A write to address 0 loads `wdata[4:0]` into the read pointer. The next read strobe returns the register at that address. `wdata[23:6]` of such a write has no effect.
- R3: A read strobe with the pointer at 0 returns 0xC7701A.
- R4: The control register is 10 bits wide and is read at bits [9:0] of the data word. Bits [7:0] are writable. Bits [9:8] and [23:10] always read as 0.
- R5: Control bit 0 selects the chip-enable source. When it is 1, `chip_on` follows `chip_en_pin`. When it is 0, the pin is ignored and `chip_on` equals control bit 1.
- R6: Control bits 2 to 7 are keep-on bits for `blk_en[0]` to `blk_en[5]`, in the order bias, phase detector, charge pump, reference buffer, VCO divider buffer, output driver. Each `blk_en[i]` is the keep-on bit OR `chip_on`.
- R7: The divider register holds `wdata[13:0]` and is read at bits [13:0] with the upper bits 0. A written value of 0 is stored as 1.
- R8: A write to address 0 with `wdata[5]`=1 puts the bank in soft reset at once. While the bank is in soft reset, the control and divider registers hold their reset values and writes to them are discarded. The read pointer still loads from that same write. A write to address 0 with `wdata[5]`=0 leaves soft reset.
- R9: Reads of addresses 3 to 31 return 0. Writes to addresses 3 to 31 change no register.
- R10: `rdata` is captured only on the clock edge where `rd_en` is high, and holds its value otherwise. A read takes the register values from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the current transaction |
| rd_en | input | 1 | Read strobe; captures the selected register |
| addr | input | 5 | Write address |
| wdata | input | 24 | Write data word |
| chip_en_pin | input | 1 | External chip-enable pin |
| rdata | output | 24 | Captured read data |
| chip_on | output | 1 | Derived chip enable |
| blk_en | output | 6 | Sub-block power enables |

## Verification
The bench first targets the indirect read path:
- Pointer writes whose upper data bits are set. A design that decoded more than 5 bits would point to the wrong register.
- The identifier read. A wrong value shows as a mismatched constant.

It then writes a divider value of 0. An unclamped design would read back 0.

Soft reset is checked while writes to the held registers are attempted. A design that let those writes through, or that cleared the pointer on soft reset, would read back the wrong register or value.

Keep-on bits are walked one at a time against both chip-enable sources. This catches swapped override order and a pin that is not ignored when software control is selected.

Writes to unimplemented addresses are followed by read-backs of the real registers. The bank also sits idle between reads to confirm that `rdata` holds its value.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
   localparam int unsigned ADR_POINTER = 0;
   localparam int unsigned ADR_CONTROL = 1;
   localparam int unsigned ADR_DIVIDER = 2;
   localparam int unsigned CTL_SRC_BIT = 0;
   localparam int unsigned CTL_SW_BIT  = 1;
   localparam int unsigned CTL_KEEP_LO = 2;
   localparam int unsigned SOFT_BIT    = 5;
   localparam int unsigned CTL_FIELD_W = 10;
endpackage

// File: rtl/cfg_ptr_ctl.sv
module cfg_ptr_ctl
   import cfg_bank_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] rd_ptr,
   output logic              soft_q,
   output logic              soft_hold
);
   localparam logic [ADDR_W-1:0] A_PTR = ADDR_W'(ADR_POINTER);

   logic ptr_wr;
   assign ptr_wr    = wr_en && (addr == A_PTR);
   assign soft_hold = ptr_wr ? wdata[SOFT_BIT] : soft_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         soft_q <= 1'b0;
      end else if (ptr_wr) begin
         rd_ptr <= wdata[ADDR_W-1:0];
         soft_q <= wdata[SOFT_BIT];
      end
   end
endmodule

// File: rtl/cfg_ctrl_regs.sv
module cfg_ctrl_regs
   import cfg_bank_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 24,
   parameter int unsigned CTL_W  = 8,
   parameter int unsigned DIV_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              soft_hold,
   output logic [CTL_W-1:0]  ctl_q,
   output logic [DIV_W-1:0]  div_q
);
   localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(ADR_CONTROL);
   localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(ADR_DIVIDER);
   localparam logic [CTL_W-1:0]  CTL_DEF = CTL_W'(3);
   localparam logic [DIV_W-1:0]  DIV_DEF = DIV_W'(1);

   logic [DIV_W-1:0] div_wr;
   assign div_wr = (wdata[DIV_W-1:0] == '0) ? DIV_DEF : wdata[DIV_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_DEF;
         div_q <= DIV_DEF;
      end else if (soft_hold) begin
         ctl_q <= CTL_DEF;
         div_q <= DIV_DEF;
      end else if (wr_en) begin
         if (addr == A_CTL) ctl_q <= wdata[CTL_W-1:0];
         if (addr == A_DIV) div_q <= div_wr;
      end
   end
endmodule

// File: rtl/cfg_en_derive.sv
module cfg_en_derive
   import cfg_bank_pkg::*;
#(
   parameter int unsigned CTL_W  = 8,
   parameter int unsigned N_KEEP = 6
) (
   input  logic [CTL_W-1:0]  ctl_q,
   input  logic              chip_en_pin,
   output logic              chip_on,
   output logic [N_KEEP-1:0] blk_en
);
   assign chip_on = ctl_q[CTL_SRC_BIT] ? chip_en_pin : ctl_q[CTL_SW_BIT];

   for (genvar g = 0; g < N_KEEP; g++) begin : g_blk
      assign blk_en[g] = ctl_q[CTL_KEEP_LO + g] | chip_on;
   end
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
   import cfg_bank_pkg::*;
#(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 24,
   parameter int unsigned CTL_W   = 8,
   parameter int unsigned DIV_W   = 14,
   parameter logic [DATA_W-1:0] CHIP_ID = 24'hC7701A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_ptr,
   input  logic [CTL_W-1:0]  ctl_q,
   input  logic [DIV_W-1:0]  div_q,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] A_PTR = ADDR_W'(ADR_POINTER);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADR_CONTROL);
   localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(ADR_DIVIDER);

   logic [DATA_W-1:0] sel;
   always_comb begin
      sel = '0;
      if (rd_ptr == A_PTR)      sel = CHIP_ID;
      else if (rd_ptr == A_CTL) sel = DATA_W'(ctl_q);
      else if (rd_ptr == A_DIV) sel = DATA_W'(div_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= sel;
   end
endmodule

// File: rtl/synth_cfg_bank.sv
module synth_cfg_bank
   import cfg_bank_pkg::*;
#(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 24,
   parameter int unsigned DIV_W   = 14,
   parameter int unsigned N_KEEP  = 6,
   parameter logic [DATA_W-1:0] CHIP_ID = 24'hC7701A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              chip_en_pin,
   output logic [DATA_W-1:0] rdata,
   output logic              chip_on,
   output logic [N_KEEP-1:0] blk_en
);
   localparam int unsigned CTL_W = CTL_KEEP_LO + N_KEEP;

   if (CTL_W > CTL_FIELD_W) begin : g_chk_ctl
      $error("keep-on field does not fit the control register");
   end
   if (DIV_W >= DATA_W || CTL_FIELD_W > DATA_W) begin : g_chk_data
      $error("data word too narrow for the register fields");
   end
   if (ADDR_W < 2 || ADDR_W > SOFT_BIT) begin : g_chk_addr
      $error("pointer width must leave the soft-reset bit clear");
   end

   logic [ADDR_W-1:0] rd_ptr;
   logic              soft_q, soft_hold;
   logic [CTL_W-1:0]  ctl_q;
   logic [DIV_W-1:0]  div_q;

   cfg_ptr_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rd_ptr(rd_ptr), .soft_q(soft_q), .soft_hold(soft_hold));

   cfg_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_W(CTL_W), .DIV_W(DIV_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .soft_hold(soft_hold), .ctl_q(ctl_q), .div_q(div_q));

   cfg_en_derive #(.CTL_W(CTL_W), .N_KEEP(N_KEEP)) u_en (
      .ctl_q(ctl_q), .chip_en_pin(chip_en_pin), .chip_on(chip_on), .blk_en(blk_en));

   cfg_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_W(CTL_W), .DIV_W(DIV_W),
                .CHIP_ID(CHIP_ID)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_ptr(rd_ptr), .ctl_q(ctl_q),
      .div_q(div_q), .rdata(rdata));
endmodule

// File: rtl/synth_cfg_bank_chk.sv
module synth_cfg_bank_chk #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 24,
   parameter int unsigned DIV_W  = 14,
   parameter int unsigned N_KEEP = 6,
   parameter int unsigned CTL_W  = 8,
   parameter logic [DATA_W-1:0] CHIP_ID = 24'hC7701A
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [ADDR_W-1:0] rd_ptr,
   input logic              soft_q,
   input logic [CTL_W-1:0]  ctl_q,
   input logic [DIV_W-1:0]  div_q,
   input logic              chip_on,
   input logic [N_KEEP-1:0] blk_en
);
   a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == '0) |=> rd_ptr == $past(wdata[ADDR_W-1:0]));

   a_r3_id_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_ptr == '0) |=> rdata == CHIP_ID);

   a_r4_ctl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_ptr == ADDR_W'(1)) |=> rdata[DATA_W-1:CTL_W] == '0);

   a_r5_off_follows_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_on |-> blk_en == ctl_q[CTL_W-1:CTL_W-N_KEEP]);

   a_r6_keep_forces_on: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[CTL_W-1:CTL_W-N_KEEP] & ~blk_en) == '0);

   a_r7_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      div_q != '0);

   a_r8_soft_defaults: assert property (@(posedge clk) disable iff (!rst_n)
      soft_q |-> (ctl_q == CTL_W'(3) && div_q == DIV_W'(1)));

   a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_ptr > ADDR_W'(2)) |=> rdata == '0);

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

bind synth_cfg_bank synth_cfg_bank_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .N_KEEP(N_KEEP),
   .CTL_W(CTL_W), .CHIP_ID(CHIP_ID)) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .rdata(rdata), .rd_ptr(rd_ptr), .soft_q(soft_q),
   .ctl_q(ctl_q), .div_q(div_q), .chip_on(chip_on), .blk_en(blk_en));

// File: tb/test_synth_cfg_bank.sv
module test_synth_cfg_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, pin = 1'b0;
   logic [4:0]  addr = '0;
   logic [23:0] wdata = '0;
   logic [23:0] rdata;
   logic        chip_on;
   logic [5:0]  blk_en;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   logic [7:0]  m_ctl;
   logic [13:0] m_div;
   logic [4:0]  m_ptr;
   bit          m_soft;
   logic [23:0] m_rd;

   always #5 clk = ~clk;

   synth_cfg_bank i_synth_cfg_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .chip_en_pin(pin), .rdata(rdata), .chip_on(chip_on),
      .blk_en(blk_en));

   function automatic logic [23:0] exp_read(input logic [4:0] p);
      case (p)
         5'd0:    return 24'hC7701A;
         5'd1:    return {16'h0, m_ctl};
         5'd2:    return {10'h0, m_div};
         default: return 24'h0;
      endcase
   endfunction

   function automatic logic exp_chip(input logic p);
      return m_ctl[0] ? p : m_ctl[1];
   endfunction

   function automatic logic [5:0] exp_blk(input logic p);
      return m_ctl[7:2] | {6{exp_chip(p)}};
   endfunction

   task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(input bit we, input bit re, input logic [4:0] a,
                      input logic [23:0] d, input bit p, input string tag);
      logic [23:0] e;
      @(negedge clk);
      wr_en = we; rd_en = re; addr = a; wdata = d; pin = p;
      e = re ? exp_read(m_ptr) : m_rd;
      @(posedge clk); #1;
      if (we) begin
         if (a == 5'd0) begin
            m_ptr  = d[4:0];
            m_soft = d[5];
            if (d[5]) begin m_ctl = 8'h03; m_div = 14'd1; end
         end else if (!m_soft) begin
            if (a == 5'd1) m_ctl = d[7:0];
            if (a == 5'd2) m_div = (d[13:0] == 0) ? 14'd1 : d[13:0];
         end
      end
      m_rd = e;
      check(tag, rdata, e);
      check("R5 chip_on", {23'h0, chip_on}, {23'h0, exp_chip(p)});
      check("R6 blk_en", {18'h0, blk_en}, {18'h0, exp_blk(p)});
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic rd_reg(input logic [4:0] r, input bit p, input string tag);
      cyc(1'b1, 1'b0, 5'd0, {19'h0, r}, p, "R2 ptr");
      cyc(1'b0, 1'b1, 5'd0, 24'h0, p, tag);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0017));
      m_ctl = 8'h03; m_div = 14'd1; m_ptr = 5'd0; m_soft = 1'b0; m_rd = 24'h0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 rdata", rdata, 24'h0);
      check("R1 chip_on", {23'h0, chip_on}, 24'h0);
      rst_n = 1'b1;
      // R3 identifier with reset pointer (R1 pointer 0)
      cyc(1'b0, 1'b1, 5'd0, 24'h0, 1'b1, "R3 id read");
      rd_reg(5'd1, 1'b0, "R1 ctl default");
      rd_reg(5'd2, 1'b0, "R1 div default");
      // R4 reserved bits
      cyc(1'b1, 1'b0, 5'd1, 24'hFFFFFF, 1'b0, "R4 write");
      rd_reg(5'd1, 1'b0, "R4 reserved zero");
      // R2 pointer upper bits ignored: 0xFFFFC1 -> ptr 1, soft 0
      cyc(1'b1, 1'b0, 5'd0, 24'hFFFFC1, 1'b0, "R2 ptr upper");
      cyc(1'b0, 1'b1, 5'd0, 24'h0, 1'b0, "R2 upper ignored");
      // R10 hold
      cyc(1'b0, 1'b0, 5'd0, 24'h0, 1'b1, "R10 hold");
      // R5 / R6 walk
      cyc(1'b1, 1'b0, 5'd1, 24'h000001, 1'b1, "R5 pin src");
      cyc(1'b0, 1'b0, 5'd0, 24'h0, 1'b0, "R5 pin low");
      cyc(1'b1, 1'b0, 5'd1, 24'h000002, 1'b0, "R5 sw on pin ignored");
      cyc(1'b1, 1'b0, 5'd1, 24'h000000, 1'b1, "R5 sw off pin ignored");
      for (int i = 0; i < 6; i++)
         cyc(1'b1, 1'b0, 5'd1, 24'h4 << i, 1'b0, "R6 keep walk");
      // R7 divider
      cyc(1'b1, 1'b0, 5'd2, 24'h000000, 1'b0, "R7 write zero");
      rd_reg(5'd2, 1'b0, "R7 clamp");
      cyc(1'b1, 1'b0, 5'd2, 24'hFFFFFF, 1'b0, "R7 write max");
      rd_reg(5'd2, 1'b0, "R7 width");
      // R9 unimplemented
      cyc(1'b1, 1'b0, 5'd1, 24'h0000A5, 1'b0, "R9 setup");
      cyc(1'b1, 1'b0, 5'd5, 24'h0000FF, 1'b0, "R9 write 5");
      cyc(1'b1, 1'b0, 5'd31, 24'hFFFFFF, 1'b0, "R9 write 31");
      rd_reg(5'd1, 1'b0, "R9 ctl kept");
      rd_reg(5'd2, 1'b0, "R9 div kept");
      rd_reg(5'd17, 1'b0, "R9 read zero");
      // R8 soft reset, pointer loaded by same write
      cyc(1'b1, 1'b0, 5'd0, 24'h000021, 1'b0, "R8 enter");
      cyc(1'b0, 1'b1, 5'd0, 24'h0, 1'b0, "R8 ctl default");
      cyc(1'b1, 1'b0, 5'd1, 24'h0000FC, 1'b1, "R8 write ignored");
      cyc(1'b1, 1'b0, 5'd2, 24'h001234, 1'b1, "R8 write ignored");
      cyc(1'b0, 1'b1, 5'd0, 24'h0, 1'b0, "R8 ctl held");
      cyc(1'b1, 1'b0, 5'd0, 24'h000002, 1'b0, "R8 leave");
      cyc(1'b0, 1'b1, 5'd0, 24'h0, 1'b0, "R8 div held");
      cyc(1'b1, 1'b0, 5'd2, 24'h000777, 1'b0, "R8 write after");
      cyc(1'b0, 1'b1, 5'd0, 24'h0, 1'b0, "R8 write after");
      // constrained random
      for (int k = 0; k < 400; k++) begin
         int unsigned s;
         logic [23:0] d;
         bit p;
         s = $urandom % 8;
         d = 24'($urandom);
         p = 1'($urandom);
         case (s)
            0, 1: begin
               d[5] = (($urandom % 10) == 0);
               if ($urandom % 4 != 0) d[4:0] = 5'($urandom % 3);
               cyc(1'b1, 1'b0, 5'd0, d, p, "R2 rand ptr");
            end
            2, 3: cyc(1'b1, 1'b0, 5'd1, d, p, "R4 rand ctl");
            4: begin
               if ($urandom % 4 == 0) d[13:0] = '0;
               cyc(1'b1, 1'b0, 5'd2, d, p, "R7 rand div");
            end
            5: cyc(1'b1, 1'b0, 5'(3 + $urandom % 29), d, p, "R9 rand write");
            default: cyc(1'b0, 1'b1, 5'd0, 24'h0, p, "R10 rand read");
         endcase
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule